// File: doc/BRIEF.md
# Mode-Selectable Fixed-Point Inverse FFT Engine

This block is an iterative radix-2 inverse FFT for a power-of-two point count N (8 by default). The user writes N complex samples, each a 32-bit signed real part and a 32-bit signed imaginary part, into an internal sample store. The user then pulses `start` and waits for `done`. Each clock cycle the engine runs one decimation-in-time butterfly. The butterfly uses a positive-angle twiddle, e^(+j2πk/N), stored with 13 fraction bits. No stage halves its outputs.

After the last butterfly, a normalise pass visits every sample once, one per cycle. The `mode` input, sampled at start, decides what that pass does. With mode 0 the engine is a standalone inverse transform: it divides every output by N using an arithmetic right shift of ceil(log2 N) bits. With mode 1 the data has already been scaled by an upstream forward transform, so the pass leaves every value unchanged and the data is never scaled twice. Results are read back in natural order through a combinational read port.

Top module: `ifft_engine`

## Requirements
- R1: After a synchronous active-low reset, `done` is 0 and every stored sample reads back as zero.
- R2: When the engine is not computing, `wr_en` stores (`wr_re`, `wr_im`) as input sample number `wr_addr`, where samples are numbered 0 to N-1 in natural order.
- R3: Results follow the fixed-point radix-2 decimation-in-time inverse transform, defined as follows:
  - The inputs are placed in bit-reversed order.
  - For stage s = 0 to log2N-1 and butterfly b = 0 to N/2-1, let h = 2^s, j = b mod h and top = (b/h)·2h + j. The butterfly pairs positions top and top+h with twiddle index k = j·N/(2h).
  - The twiddle is W = (round(cos(2πk/N)·8192), round(sin(2πk/N)·8192)).
  - The product p = B·W has each part formed from the full-precision sum and then arithmetic-shifted right by 13.
  - Position top becomes A+p and position top+h becomes A−p, each wrapped to 32 bits.
- R4: With mode 0, every output equals its butterfly result arithmetic-shifted right by ceil(log2 N). Negative values round toward minus infinity.
- R5: With mode 1, every output equals its butterfly result unchanged.
- R6: `done` rises exactly log2N·N/2 + N clock cycles after the cycle in which `start` is accepted.
- R7: `done` stays 1 until the next `start`. A `start` accepted while `done` is 1 drives `done` to 0 on the following cycle and begins a new run.
- R8: While computing, `start` and `wr_en` are ignored. The run length and the results are unaffected.
- R9: `mode` is captured when `start` is accepted. Changing `mode` while computing has no effect.
- R10: `rd_re`/`rd_im` show, combinationally, output sample number `rd_addr` of the finished run.
- R11: An input with only sample 0 nonzero (value A) yields A in the real part of every output under mode 1, and A>>>log2N under mode 0, with all imaginary parts 0.
- R12: The twiddle has a positive imaginary part. For N=8, an input with only sample 1 equal to 1000 and mode 1 yields output 2 = (0, +1000) and output 1 = (707, 707).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run on the stored samples |
| mode | input | 1 | 0: divide outputs by N; 1: leave unscaled |
| wr_en | input | 1 | Sample write strobe |
| wr_addr | input | log2(N) | Input sample number to write |
| wr_re | input | 32 | Real part of written sample |
| wr_im | input | 32 | Imaginary part of written sample |
| rd_addr | input | log2(N) | Output sample number to read |
| rd_re | output | 32 | Real part of selected output |
| rd_im | output | 32 | Imaginary part of selected output |
| done | output | 1 | Run finished; results valid |

## Verification
The bench builds the engine with its default N=8. With that value all three butterfly stages run, the scaling shift is 3 bits, and the twiddle set includes both the exact quarter-turn values and the rounded 5793 diagonal values. A 20-cycle run lets the bench count latency to the exact cycle. The bench also injects `start`, `wr_en` and `mode` changes in the middle of a run. Both normalise modes are exercised, along with negative data so that the arithmetic shift rounds down.

// File: rtl/ifft_pkg.sv
// Package: shared sample type, controller states and constant twiddle
// generation for the inverse FFT engine. Assumes twiddles fit in 32 bits.
package ifft_pkg;

    localparam int  SAMPLE_W = 32;
    localparam int  TW_FRAC  = 13;
    localparam real PI_R     = 3.14159265358979323846;

    typedef struct packed {
        logic signed [SAMPLE_W-1:0] re;
        logic signed [SAMPLE_W-1:0] im;
    } cplx_t;

    typedef enum logic [1:0] {ST_IDLE, ST_CALC, ST_DONE} ctl_state_t;

    // Taylor series sine, adequate for |x| <= 2*pi.
    function automatic real sin_series(input real x);
        real term;
        real acc;
        term = x;
        acc  = x;
        for (int i = 1; i < 18; i++) begin
            term = -term * x * x / real'((2 * i) * (2 * i + 1));
            acc  = acc + term;
        end
        return acc;
    endfunction

    // Taylor series cosine, adequate for |x| <= 2*pi.
    function automatic real cos_series(input real x);
        real term;
        real acc;
        term = 1.0;
        acc  = 1.0;
        for (int i = 1; i < 18; i++) begin
            term = -term * x * x / real'((2 * i - 1) * (2 * i));
            acc  = acc + term;
        end
        return acc;
    endfunction

    // Rounded fixed-point cosine of 2*pi*k/n.
    function automatic int tw_cos(input int k, input int n);
        return int'(cos_series(2.0 * PI_R * real'(k) / real'(n)) * real'(1 << TW_FRAC));
    endfunction

    // Rounded fixed-point sine of 2*pi*k/n (positive angle for the inverse).
    function automatic int tw_sin(input int k, input int n);
        return int'(sin_series(2.0 * PI_R * real'(k) / real'(n)) * real'(1 << TW_FRAC));
    endfunction

endpackage

// File: rtl/ifft_twiddle_rom.sv
// Module: constant twiddle table for the inverse transform.
// Holds e^(+j*2*pi*k/N) in Q(TW_FRAC) for k = 0..N-1, built at elaboration.
// Assumes N is a power of two.
module ifft_twiddle_rom
    import ifft_pkg::*;
#(
    parameter int N = 8,
    localparam int AW = $clog2(N)
) (
    input  logic [AW-1:0] k,
    output cplx_t         w
);

    cplx_t tbl [N];

    // One constant entry per twiddle index.
    for (genvar g = 0; g < N; g++) begin : g_tw
        localparam int C = tw_cos(g, N);
        localparam int S = tw_sin(g, N);
        assign tbl[g] = '{re: SAMPLE_W'(C), im: SAMPLE_W'(S)};
    end

    // Table lookup.
    assign w = tbl[k];

endmodule

// File: rtl/ifft_butterfly.sv
// Module: radix-2 butterfly with fixed-point complex multiply.
// Computes p = (b * w) >>> TW_FRAC per part from a full-precision sum,
// then top = a + p and bot = a - p, wrapped to SAMPLE_W. No halving.
module ifft_butterfly
    import ifft_pkg::*;
(
    input  cplx_t a,
    input  cplx_t b,
    input  cplx_t w,
    output cplx_t top,
    output cplx_t bot
);

    localparam int PROD_W = 2 * SAMPLE_W + 1;

    logic signed [PROD_W-1:0]   rr, ii, ri, ir, sum_re, sum_im;
    logic signed [SAMPLE_W-1:0] p_re, p_im;

    // Complex product with truncating rescale.
    always_comb begin
        rr     = PROD_W'(b.re) * PROD_W'(w.re);
        ii     = PROD_W'(b.im) * PROD_W'(w.im);
        ri     = PROD_W'(b.re) * PROD_W'(w.im);
        ir     = PROD_W'(b.im) * PROD_W'(w.re);
        sum_re = rr - ii;
        sum_im = ri + ir;
        p_re   = SAMPLE_W'(sum_re >>> TW_FRAC);
        p_im   = SAMPLE_W'(sum_im >>> TW_FRAC);
    end

    // Sum and difference outputs.
    always_comb begin
        top.re = a.re + p_re;
        top.im = a.im + p_im;
        bot.re = a.re - p_re;
        bot.im = a.im - p_im;
    end

endmodule

// File: rtl/ifft_ctrl.sv
// Module: three-state controller (idle, computing, done) for the engine.
// Steps one butterfly per cycle through log2(N) DIT stages, then one
// normalise write per sample, then holds done until the next start.
module ifft_ctrl
    import ifft_pkg::*;
#(
    parameter int N = 8,
    localparam int AW    = $clog2(N),
    localparam int HALF  = N / 2,
    localparam int STG_W = (AW > 1) ? $clog2(AW) : 1,
    localparam int TOTAL = AW * HALF + N
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output ctl_state_t    state,
    output logic          accept,
    output logic          bf_we,
    output logic [AW-1:0] top_idx,
    output logic [AW-1:0] bot_idx,
    output logic [AW-1:0] tw_idx,
    output logic          norm_we,
    output logic [AW-1:0] norm_idx
);

    logic [STG_W-1:0] stage;
    logic [AW-1:0]    bf_cnt;
    logic             norm_phase;
    logic [AW-1:0]    half, j, grp;

    assign accept   = start && (state != ST_CALC);
    assign bf_we    = (state == ST_CALC) && !norm_phase;
    assign norm_we  = (state == ST_CALC) && norm_phase;

    // Butterfly pair and twiddle index for the current stage and count.
    always_comb begin
        half    = AW'(1) << stage;
        j       = bf_cnt & (half - AW'(1));
        grp     = bf_cnt >> stage;
        top_idx = ((grp << stage) << 1) | j;
        bot_idx = top_idx | half;
        tw_idx  = AW'(j << (AW - 1 - int'(stage)));
    end

    // State and counter sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            stage      <= '0;
            bf_cnt     <= '0;
            norm_phase <= 1'b0;
            norm_idx   <= '0;
        end else begin
            case (state)
                ST_CALC: begin
                    if (!norm_phase) begin
                        if (bf_cnt == AW'(HALF - 1)) begin
                            bf_cnt <= '0;
                            if (stage == STG_W'(AW - 1)) begin
                                norm_phase <= 1'b1;
                            end else begin
                                stage <= stage + STG_W'(1);
                            end
                        end else begin
                            bf_cnt <= bf_cnt + AW'(1);
                        end
                    end else if (norm_idx == AW'(N - 1)) begin
                        state <= ST_DONE;
                    end else begin
                        norm_idx <= norm_idx + AW'(1);
                    end
                end
                default: begin
                    if (start) begin
                        state      <= ST_CALC;
                        stage      <= '0;
                        bf_cnt     <= '0;
                        norm_phase <= 1'b0;
                        norm_idx   <= '0;
                    end
                end
            endcase
        end
    end

    // Checker counter: cycles spent computing since the last accepted start.
    logic [$clog2(TOTAL + 2)-1:0] calc_cycles;
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            calc_cycles <= '0;
        end else if (state == ST_CALC) begin
            calc_cycles <= calc_cycles + 1'b1;
        end
    end

    // R6: run length from accepted start to done.
    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && $past(state) == ST_CALC) |-> (calc_cycles == TOTAL));

    // R7: done is held while no start arrives.
    p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && !start) |=> (state == ST_DONE));

    // R8: start seen while computing does not restart the counters.
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bf_we && start && !(bf_cnt == '0 && stage == '0)) |=>
            !(bf_cnt == '0 && stage == '0 && !norm_phase));

endmodule

// File: rtl/ifft_engine.sv
// Module: top of the mode-selectable inverse FFT engine.
// Owns the sample store: loads in bit-reversed position, applies one
// butterfly per cycle in place, then normalises each sample (shift by
// ceil(log2 N) when mode=0, pass when mode=1). N must be a power of two, N>=4.
module ifft_engine
    import ifft_pkg::*;
#(
    parameter int N = 8,
    localparam int AW    = $clog2(N),
    localparam int SHIFT = $clog2(N)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       mode,
    input  logic                       wr_en,
    input  logic [AW-1:0]              wr_addr,
    input  logic signed [SAMPLE_W-1:0] wr_re,
    input  logic signed [SAMPLE_W-1:0] wr_im,
    input  logic [AW-1:0]              rd_addr,
    output logic signed [SAMPLE_W-1:0] rd_re,
    output logic signed [SAMPLE_W-1:0] rd_im,
    output logic                       done
);

    cplx_t         mem [N];
    ctl_state_t    state;
    logic          accept, bf_we, norm_we, mode_q;
    logic [AW-1:0] top_idx, bot_idx, tw_idx, norm_idx, wr_rev;
    cplx_t         tw, bf_top, bf_bot, norm_cur, norm_val;

    ifft_ctrl #(.N(N)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .state    (state),
        .accept   (accept),
        .bf_we    (bf_we),
        .top_idx  (top_idx),
        .bot_idx  (bot_idx),
        .tw_idx   (tw_idx),
        .norm_we  (norm_we),
        .norm_idx (norm_idx)
    );

    ifft_twiddle_rom #(.N(N)) u_rom (
        .k (tw_idx),
        .w (tw)
    );

    ifft_butterfly u_bfly (
        .a   (mem[top_idx]),
        .b   (mem[bot_idx]),
        .w   (tw),
        .top (bf_top),
        .bot (bf_bot)
    );

    // Bit-reversed store position for an incoming sample number.
    always_comb begin
        for (int i = 0; i < AW; i++) begin
            wr_rev[i] = wr_addr[AW-1-i];
        end
    end

    // Normalise value: divide by N or pass, per captured mode.
    always_comb begin
        norm_cur = mem[norm_idx];
        if (mode_q) begin
            norm_val = norm_cur;
        end else begin
            norm_val.re = norm_cur.re >>> SHIFT;
            norm_val.im = norm_cur.im >>> SHIFT;
        end
    end

    // Mode capture on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else if (accept) begin
            mode_q <= mode;
        end
    end

    // Sample store: load, in-place butterfly, normalise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en && state != ST_CALC) begin
            mem[wr_rev] <= '{re: wr_re, im: wr_im};
        end else if (bf_we) begin
            mem[top_idx] <= bf_top;
            mem[bot_idx] <= bf_bot;
        end else if (norm_we) begin
            mem[norm_idx] <= norm_val;
        end
    end

    // Result readout and completion flag.
    assign rd_re = mem[rd_addr].re;
    assign rd_im = mem[rd_addr].im;
    assign done  = (state == ST_DONE);

    // R4: mode 0 normalise divides the visited sample by N.
    p_norm_div_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (norm_we && !mode_q) |=>
            (mem[$past(norm_idx)].re == ($signed($past(norm_cur.re)) >>> SHIFT)) &&
            (mem[$past(norm_idx)].im == ($signed($past(norm_cur.im)) >>> SHIFT)));

    // R5: mode 1 normalise leaves the visited sample unchanged.
    p_norm_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (norm_we && mode_q) |=> (mem[$past(norm_idx)] == $past(norm_cur)));

    // R9: captured mode does not move during a run.
    p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CALC) |=> $stable(mode_q));

    // R8: a write strobe during normalise does not disturb the written slot.
    p_wr_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (norm_we && wr_en) |=> (mem[$past(norm_idx)] == $past(norm_val)));

endmodule

// File: tb/ifft_engine_test.sv
// Scoreboard bench: the driver loads samples, models the expected outputs
// and queues them; the monitor drains the queue through the read port.
module ifft_engine_test;

    localparam int CLK_PERIOD = 10;
    localparam int NP  = 8;
    localparam int LG  = 3;
    localparam int LAT = LG * NP / 2 + NP;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              mode = 1'b0;
    logic              wr_en = 1'b0;
    logic [LG-1:0]     wr_addr = '0;
    logic signed [31:0] wr_re = '0;
    logic signed [31:0] wr_im = '0;
    logic [LG-1:0]     rd_addr = '0;
    logic signed [31:0] rd_re, rd_im;
    logic              done;

    int errors = 0;
    int checks = 0;
    int jobs = 0;
    int drained = 0;

    int stim_re [NP];
    int stim_im [NP];

    typedef struct {
        int    idx;
        int    re;
        int    im;
        string tag;
    } exp_t;
    exp_t sbq [$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    ifft_engine #(.N(NP)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_re(wr_re), .wr_im(wr_im),
        .rd_addr(rd_addr), .rd_re(rd_re), .rd_im(rd_im), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int bitrev(input int v);
        int r = 0;
        for (int i = 0; i < LG; i++) if (v[i]) r |= 1 << (LG - 1 - i);
        return r;
    endfunction

    // Reference per R3/R4/R5: fixed-point DIT inverse transform from the stimulus.
    task automatic model_push(input bit md, input string tag);
        longint ar [NP];
        longint ai [NP];
        for (int i = 0; i < NP; i++) begin
            ar[bitrev(i)] = stim_re[i];
            ai[bitrev(i)] = stim_im[i];
        end
        for (int s = 0; s < LG; s++) begin
            for (int b = 0; b < NP / 2; b++) begin
                int h  = 1 << s;
                int jj = b % h;
                int tp = (b / h) * 2 * h + jj;
                int k  = jj * NP / (2 * h);
                longint wr = longint'($cos(2.0 * 3.14159265358979 * k / NP) * 8192.0);
                longint wi = longint'($sin(2.0 * 3.14159265358979 * k / NP) * 8192.0);
                longint pr = (ar[tp + h] * wr - ai[tp + h] * wi) >>> 13;
                longint pi = (ar[tp + h] * wi + ai[tp + h] * wr) >>> 13;
                longint xr = ar[tp];
                longint xi = ai[tp];
                ar[tp]     = longint'(int'(xr + pr));
                ai[tp]     = longint'(int'(xi + pi));
                ar[tp + h] = longint'(int'(xr - pr));
                ai[tp + h] = longint'(int'(xi - pi));
            end
        end
        for (int i = 0; i < NP; i++) begin
            exp_t e;
            e.idx = i;
            e.re  = md ? int'(ar[i]) : int'(ar[i] >>> LG);
            e.im  = md ? int'(ai[i]) : int'(ai[i] >>> LG);
            e.tag = tag;
            sbq.push_back(e);
        end
    endtask

    task automatic clear_stim();
        for (int i = 0; i < NP; i++) begin
            stim_re[i] = 0;
            stim_im[i] = 0;
        end
    endtask

    // Driver: load (R2), queue expectations, start, time the run (R6, R7),
    // optionally disturb with start, wr_en and mode (R8, R9).
    task automatic run_job(input bit md, input string tag, input bit disturb,
                           input int extra_idx, input int extra_re,
                           input int extra_im, input string extra_tag);
        int cnt;
        bit seen;
        for (int i = 0; i < NP; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = LG'(i); wr_re = stim_re[i]; wr_im = stim_im[i];
        end
        @(negedge clk);
        wr_en = 1'b0;
        model_push(md, tag);
        if (extra_idx >= 0) begin
            exp_t e;
            e.idx = extra_idx; e.re = extra_re; e.im = extra_im; e.tag = extra_tag;
            sbq.push_back(e);
        end
        jobs++;
        mode = md; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) mode = ~md;
        cnt = 0; seen = 1'b0;
        while (!seen && cnt < 200) begin
            @(posedge clk); #1;
            cnt++;
            if (cnt == 1) chk(done == 1'b0, "R7", "done after start", done, 0);
            if (disturb && cnt == 3) begin
                wr_en = 1'b1; wr_addr = '0; wr_re = 12345; wr_im = -999; start = 1'b1;
            end
            if (disturb && cnt == 4) begin
                wr_en = 1'b0; start = 1'b0;
            end
            if (disturb && cnt == 16) begin
                wr_en = 1'b1; wr_addr = 3'd5; wr_re = 777; wr_im = 777;
            end
            if (disturb && cnt == 17) wr_en = 1'b0;
            seen = done;
        end
        chk(cnt == LAT, "R6", {"latency ", tag}, cnt, LAT);
        wait (drained == jobs);
        repeat (3) @(negedge clk);
        chk(done == 1'b1, "R7", "done held", done, 1);
        mode = 1'b0;
    endtask

    // Monitor: on done, read every queued index through the port (R10).
    initial begin
        forever begin
            @(posedge done);
            while (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                @(negedge clk);
                rd_addr = LG'(e.idx);
                #1;
                chk(rd_re == e.re, {e.tag, " R10"}, $sformatf("re[%0d]", e.idx), rd_re, e.re);
                chk(rd_im == e.im, {e.tag, " R10"}, $sformatf("im[%0d]", e.idx), rd_im, e.im);
            end
            drained++;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        errors++; checks++;
        $display("FAIL R6 watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(done == 1'b0, "R1", "done after reset", done, 0);
        rd_addr = 3'd4; #1;
        chk(rd_re == 0 && rd_im == 0, "R1", "cleared sample", rd_re, 0);

        // R11 with R4: impulse at sample 0, divided by N.
        clear_stim(); stim_re[0] = 100;
        run_job(1'b0, "R11 R4", 1'b0, -1, 0, 0, "");

        // R11 with R5: same impulse, unscaled.
        run_job(1'b1, "R11 R5", 1'b0, -1, 0, 0, "");

        // R12: positive twiddle rotation, explicit output 2 and output 1.
        clear_stim(); stim_re[1] = 1000;
        run_job(1'b1, "R3 R12", 1'b0, 2, 0, 1000, "R12");
        clear_stim(); stim_re[1] = 1000;
        run_job(1'b1, "R3 R12", 1'b0, 1, 707, 707, "R12");

        // R3 with R4: mixed data, standalone inverse.
        stim_re = '{40, -25, 13, 7, -60, 22, 0, 31};
        stim_im = '{0, 15, -8, 3, 11, -19, 5, -2};
        run_job(1'b0, "R3 R4", 1'b0, -1, 0, 0, "");

        // R4: negative impulse rounds toward minus infinity (-100>>>3 = -13).
        clear_stim(); stim_re[0] = -100; stim_im[0] = -9;
        run_job(1'b0, "R4 R11", 1'b0, -1, 0, 0, "");

        // R8 and R9: start, writes and a mode flip during the run are ignored.
        stim_re = '{-300, 120, 55, -8, 64, 0, -17, 91};
        stim_im = '{12, -40, 7, 200, -3, 18, 0, -66};
        run_job(1'b1, "R8 R9 R2", 1'b1, -1, 0, 0, "");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule